// File: doc/BRIEF.md
# Compare Flags and Condition Evaluator

This block compares two 64-bit operands at one of four operand widths and forms a seven-bit flag word. The flags are negative, zero, carry, overflow, equal, greater and less-than. A mode input selects whether greater and less-than use the unsigned or the signed ordering. The flag word is placed in the low bits of a 64-bit status word whose upper bits are always zero. The word is registered, so it appears one clock after the compare strobe and holds until the next strobe.

A second, independent path evaluates an 8-bit condition byte against a 7-bit flag word supplied by the caller. Conditional branch, call, break and select logic use this result. The low seven bits of the byte select flags, and the result is true when any selected flag is set. Bit 7 inverts that result. The taken result is registered and appears one clock after its inputs. Floating-point compare, the register file and the storage of the status register belong to the surrounding pipeline.

Top module: `cmpc_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `status_word`, `status_valid` and `cond_taken` are all zero.
- R2: The flag positions in `status_word` are N=bit0, Z=bit1, C=bit2, V=bit3, E=bit4, G=bit5 and L=bit6. Bits 63:7 are always zero. A compare presented with `cmp_valid` high at one rising edge updates all seven flags at that edge, and `status_valid` is high for that following cycle only. Without `cmp_valid`, `status_word` holds its value.
- R3: `cmp_len` selects the operand width: 00 selects 64 bits, 01 selects 32, 10 selects 16 and 11 selects 8. Operand bits above the selected width have no effect on any flag.
- R4: N is the top bit of lhs minus rhs at the selected width, and Z is set when that difference is zero. C is set when the subtraction needs no borrow, which means unsigned lhs >= rhs. V is set on two's-complement overflow of the subtraction.
- R5: E equals Z. With `cmp_signed`=0, G is set for unsigned lhs > rhs and L is set for unsigned lhs < rhs. At most one of E, G and L is set.
- R6: With `cmp_signed`=1, G and L follow the signed (two's-complement) ordering of the operands at the selected width.
- R7: One clock after its inputs, `cond_taken` equals (OR over `cond_byte[6:0]` AND `cond_flags`) XOR `cond_byte[7]`. A byte of 0x00 gives 0, and 0x80 gives 1.
- R8: The condition byte 0xB0 evaluates as not (G or E). When it is fed the flags of an equal compare it gives 0, and when it is fed the flags of a less-than compare it gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_len | input | 2 | Operand width code |
| cmp_signed | input | 1 | 1 selects signed ordering for G and L |
| cmp_lhs | input | 64 | Left operand |
| cmp_rhs | input | 64 | Right operand |
| cond_flags | input | 7 | Flag word that the condition is tested against |
| cond_byte | input | 8 | Condition byte (mask in bits 6:0, invert in bit 7) |
| status_word | output | 64 | Registered flag word, upper bits zero |
| status_valid | output | 1 | High for one cycle after each compare |
| cond_taken | output | 1 | Registered condition result |

## Verification
A wrong alignment shift or a wrong borrow convention shows up in the flags on the cycle after the compare that exposes it. This happens most often at narrow widths that carry junk in the upper operand bits, and at sign-boundary values. A wrong choice of ordering flips G and L only for operand pairs whose sign bits differ, so the stimulus deliberately includes such pairs. Every cycle's status word, valid flag and condition result are compared against a behavioural model. A bad output is therefore reported in the very cycle it first appears.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  localparam int FLAG_N   = 0;
  localparam int FLAG_Z   = 1;
  localparam int FLAG_C   = 2;
  localparam int FLAG_V   = 3;
  localparam int FLAG_E   = 4;
  localparam int FLAG_G   = 5;
  localparam int FLAG_L   = 6;
  localparam int NUM_FLAGS = 7;
  localparam int NUM_LENS  = 4;

  typedef enum logic [1:0] {
    LEN_FULL = 2'b00,
    LEN_HALF = 2'b01,
    LEN_QTR  = 2'b10,
    LEN_BYTE = 2'b11
  } len_code_e;
endpackage

// File: rtl/cmpc_align.sv
module cmpc_align #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        len,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] lhs_al,
  output logic [DATA_W-1:0] rhs_al
);
  import cmpc_pkg::*;

  logic [DATA_W-1:0] cand_l [NUM_LENS];
  logic [DATA_W-1:0] cand_r [NUM_LENS];

  // Each width variant moves its operand slice to the top of the word so
  // that the sign bit and the borrow sit at fixed positions.
  for (genvar g = 0; g < NUM_LENS; g++) begin : g_len
    localparam int SH = DATA_W - (DATA_W >> g);
    assign cand_l[g] = lhs << SH;
    assign cand_r[g] = rhs << SH;
  end

  assign lhs_al = cand_l[len];
  assign rhs_al = cand_r[len];
endmodule

// File: rtl/cmpc_flags.sv
module cmpc_flags #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]          a_al,
  input  logic [DATA_W-1:0]          b_al,
  input  logic                       sgn,
  output logic [cmpc_pkg::NUM_FLAGS-1:0] flags
);
  import cmpc_pkg::*;

  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] res;
  logic n, z, c, v, gt, lt;

  always_comb begin
    diff = {1'b0, a_al} - {1'b0, b_al};
    res  = diff[DATA_W-1:0];
    n    = res[DATA_W-1];
    z    = (res == '0);
    c    = ~diff[DATA_W];
    v    = (a_al[DATA_W-1] != b_al[DATA_W-1]) && (res[DATA_W-1] != a_al[DATA_W-1]);
    if (sgn) begin
      lt = (n != v);
      gt = (n == v) && !z;
    end else begin
      lt = !c;
      gt = c && !z;
    end
    flags         = '0;
    flags[FLAG_N] = n;
    flags[FLAG_Z] = z;
    flags[FLAG_C] = c;
    flags[FLAG_V] = v;
    flags[FLAG_E] = z;
    flags[FLAG_G] = gt;
    flags[FLAG_L] = lt;
  end
endmodule

// File: rtl/cmpc_cond.sv
module cmpc_cond #(
  parameter int FLAG_W = 7
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W:0]   cond,
  output logic              taken
);
  logic any_hit;
  assign any_hit = |(cond[FLAG_W-1:0] & flags);
  assign taken   = any_hit ^ cond[FLAG_W];
endmodule

// File: rtl/cmpc_top.sv
module cmpc_top #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_len,
  input  logic              cmp_signed,
  input  logic [DATA_W-1:0] cmp_lhs,
  input  logic [DATA_W-1:0] cmp_rhs,
  input  logic [6:0]        cond_flags,
  input  logic [7:0]        cond_byte,
  output logic [DATA_W-1:0] status_word,
  output logic              status_valid,
  output logic              cond_taken
);
  import cmpc_pkg::*;

  localparam int FW = NUM_FLAGS;

  logic [DATA_W-1:0] lhs_al, rhs_al;
  logic [FW-1:0]     flags_nx;
  logic [FW-1:0]     flags_q;
  logic              taken_nx;

  cmpc_align #(.DATA_W(DATA_W)) u_align (
    .len(cmp_len), .lhs(cmp_lhs), .rhs(cmp_rhs),
    .lhs_al(lhs_al), .rhs_al(rhs_al)
  );

  cmpc_flags #(.DATA_W(DATA_W)) u_flags (
    .a_al(lhs_al), .b_al(rhs_al), .sgn(cmp_signed), .flags(flags_nx)
  );

  cmpc_cond #(.FLAG_W(FW)) u_cond (
    .flags(cond_flags), .cond(cond_byte), .taken(taken_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q      <= '0;
      status_valid <= 1'b0;
      cond_taken   <= 1'b0;
    end else begin
      if (cmp_valid) flags_q <= flags_nx;
      status_valid <= cmp_valid;
      cond_taken   <= taken_nx;
    end
  end

  assign status_word = {{(DATA_W-FW){1'b0}}, flags_q};

  // R2: a strobe produces valid status, and without one the word holds
  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> status_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(status_word));

  // R3: equal low bytes compare equal at byte width whatever lies above
  p_narrow_eq_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_len == LEN_BYTE && cmp_lhs[7:0] == cmp_rhs[7:0])
    |=> status_word[FLAG_E]);

  // R4 / R5: full-width unsigned less-than borrows and sets L
  p_borrow_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_signed && cmp_len == LEN_FULL && cmp_lhs < cmp_rhs)
    |=> (status_word[FLAG_L] && !status_word[FLAG_C]));

  // R5: the ordering flags are mutually exclusive
  p_order_excl_r5: assert property (@(posedge clk) disable iff (rst)
    status_valid |-> $countones(status_word[FLAG_L:FLAG_E]) <= 1);

  // R6: full-width signed less-than sets L
  p_signed_lt_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_signed && cmp_len == LEN_FULL &&
     $signed(cmp_lhs) < $signed(cmp_rhs)) |=> status_word[FLAG_L]);

  // R7: the two degenerate condition bytes
  p_never_r7: assert property (@(posedge clk) disable iff (rst)
    (cond_byte == 8'h00) |=> !cond_taken);
  p_always_r7: assert property (@(posedge clk) disable iff (rst)
    (cond_byte == 8'h80) |=> cond_taken);

  // R8: not (greater or equal) is taken when neither G nor E is set
  p_not_ge_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_byte == 8'hB0 && cond_flags[FLAG_G] == 1'b0 && cond_flags[FLAG_E] == 1'b0)
    |=> cond_taken);
endmodule

// File: tb/test_cmpc_top.sv
`timescale 1ns/1ps
module test_cmpc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmp_valid;
  logic [1:0]  cmp_len;
  logic        cmp_signed;
  logic [63:0] cmp_lhs, cmp_rhs;
  logic [6:0]  cond_flags;
  logic [7:0]  cond_byte;
  logic [63:0] status_word;
  logic        status_valid;
  logic        cond_taken;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [6:0] e_st;
  logic       e_v, e_t, e_sg;
  logic [1:0] e_len;

  always #2.5 clk = ~clk;

  cmpc_top i_cmpc_top (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_len(cmp_len),
    .cmp_signed(cmp_signed), .cmp_lhs(cmp_lhs), .cmp_rhs(cmp_rhs),
    .cond_flags(cond_flags), .cond_byte(cond_byte),
    .status_word(status_word), .status_valid(status_valid), .cond_taken(cond_taken)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_flags(input logic [63:0] l, input logic [63:0] r,
                                           input logic [1:0] len, input logic sg);
    int w = 64 >> len;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] a = l & m;
    logic [63:0] b = r & m;
    logic [63:0] d = (a - b) & m;
    longint sa = $signed(a << (64 - w)) >>> (64 - w);
    longint sb = $signed(b << (64 - w)) >>> (64 - w);
    logic n = d[w-1];
    logic z = (d == 0);
    logic c = (a >= b);
    logic v = (a[w-1] != b[w-1]) && (d[w-1] != a[w-1]);
    logic gt = sg ? (sa > sb) : (a > b);
    logic lt = sg ? (sa < sb) : (a < b);
    return {lt, gt, z, v, c, z, n};
  endfunction

  function automatic logic ref_cond(input logic [6:0] f, input logic [7:0] cb);
    return (|(cb[6:0] & f)) ^ cb[7];
  endfunction

  // One clock: predict from the inputs the design samples, then compare.
  task automatic step();
    if (rst) begin
      e_st = '0; e_v = 1'b0; e_t = 1'b0;
    end else begin
      if (cmp_valid) begin
        e_st = ref_flags(cmp_lhs, cmp_rhs, cmp_len, cmp_signed);
        e_sg = cmp_signed; e_len = cmp_len;
      end
      e_v = cmp_valid;
      e_t = ref_cond(cond_flags, cond_byte);
    end
    @(posedge clk);
    @(negedge clk);
    if (!rst) begin
      chk("R2 upper bits and valid", {status_word[63:7], status_valid}, {57'd0, e_v});
      chk((e_len != 2'b00) ? "R3 R4 narrow NZCV" : "R4 NZCV", {60'd0, status_word[3:0]}, {60'd0, e_st[3:0]});
      chk(e_sg ? "R6 signed EGL" : "R5 unsigned EGL", {61'd0, status_word[6:4]}, {61'd0, e_st[6:4]});
      chk("R7 cond", {63'd0, cond_taken}, {63'd0, e_t});
    end
  endtask

  task automatic do_cmp(input logic [63:0] l, input logic [63:0] r,
                        input logic [1:0] len, input logic sg);
    cmp_valid = 1'b1; cmp_lhs = l; cmp_rhs = r; cmp_len = len; cmp_signed = sg;
    step();
    cmp_valid = 1'b0;
  endtask

  function automatic logic [63:0] pick(input int sel);
    case (sel)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'hA5A5_A5A5_0000_8000;
      5: return 64'h1234_5678_8000_007F;
      6: return 64'h0000_0001_7FFF_0080;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmp_valid = 1'b0; cmp_len = 2'b00; cmp_signed = 1'b0;
    cmp_lhs = '0; cmp_rhs = '0; cond_flags = '0; cond_byte = '0;
    e_sg = 1'b0; e_len = 2'b00;
    @(negedge clk);
    cmp_valid = 1'b1; cmp_lhs = 64'd1; cond_byte = 8'h80;
    repeat (3) step();
    chk("R1 reset status", status_word, 64'd0);
    chk("R1 reset valid", {63'd0, status_valid}, 64'd0);
    chk("R1 reset cond", {63'd0, cond_taken}, 64'd0);
    rst = 1'b0; cmp_valid = 1'b0; cond_byte = 8'h00;
    step();
    chk("R1 first cycle after reset", {status_word[62:0], status_valid}, 64'd0);

    // R7 degenerate condition bytes
    cond_flags = 7'h7F; cond_byte = 8'h00; step();
    chk("R7 zero byte false", {63'd0, cond_taken}, 64'd0);
    cond_flags = 7'h00; cond_byte = 8'h80; step();
    chk("R7 0x80 always true", {63'd0, cond_taken}, 64'd1);

    // R3 junk above the selected width
    do_cmp(64'hFFFF_FFFF_FFFF_FF05, 64'h0000_0000_0000_0005, 2'b11, 1'b0);
    chk("R3 byte width ignores upper bits", {63'd0, status_word[4]}, 64'd1);
    do_cmp(64'h0000_0001_8000_0000, 64'h0000_0000_7FFF_FFFF, 2'b01, 1'b1);
    chk("R3 R6 dword signed min < max", {63'd0, status_word[6]}, 64'd1);
    do_cmp(64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF, 2'b10, 1'b0);
    chk("R5 word unsigned 0x8000 > 0x7FFF", {63'd0, status_word[5]}, 64'd1);
    chk("R4 word overflow V", {63'd0, status_word[3]}, 64'd1);

    // R8 not (greater or equal)
    do_cmp(64'd5, 64'd5, 2'b00, 1'b0);
    cond_flags = status_word[6:0]; cond_byte = 8'hB0; step();
    chk("R8 equal gives not taken", {63'd0, cond_taken}, 64'd0);
    do_cmp(64'd3, 64'd9, 2'b00, 1'b1);
    cond_flags = status_word[6:0]; cond_byte = 8'hB0; step();
    chk("R8 less gives taken", {63'd0, cond_taken}, 64'd1);

    // Mixed random and boundary stimulus, model compared every cycle
    for (int i = 0; i < 1500; i++) begin
      int s = $urandom_range(0, 9);
      cmp_valid  = ($urandom_range(0, 3) != 0);
      cmp_len    = 2'($urandom_range(0, 3));
      cmp_signed = 1'($urandom_range(0, 1));
      cmp_lhs    = pick(s);
      cmp_rhs    = ($urandom_range(0, 4) == 0) ? cmp_lhs : pick($urandom_range(0, 9));
      cond_flags = 7'($urandom);
      cond_byte  = 8'($urandom);
      step();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule